// File: doc/BRIEF.md
# Serial bus master field sequencer

This block is the master side of a multi-unit serial bus, used after the master has won the bus. A start pulse captures a 12-bit target address, a broadcast flag and a 4-bit control code. The block then sends two fields, one bit per bit-slot strobe. The address field is the target address sent MSB first, then an even parity bit, then an acknowledge slot. The control field has the same layout: four control bits MSB first, an even parity bit and an acknowledge slot. The bit-slot strobe marks the end of the current slot, and the next slot appears on the cycle after it. In an acknowledge slot the master releases the line, raises a flag and reads the sampled line level when the strobe arrives.

A sampled 0 in an acknowledge slot means the slave acknowledged. If a directed transfer gets no acknowledge on either field, the master gives up and returns to monitoring the bus. The block signals this with a one-cycle abort pulse. A broadcast reaches many units, so the master does not wait for any one of them: it ignores both acknowledges. A completed control field gives a one-cycle success pulse. Both pulses leave the sequencer idle and ready for the next start.

Top module: `fseq_master`

## Requirements
- R1: After reset and while idle, `tx_bit_o` is 1, `ack_slot_o` is 0, and `done_o` and `abort_o` are 0.
- R2: A start pulse while idle makes the next 12 slots carry the target address, most significant bit first. The sequencer advances one slot on each cycle that `slot_stb_i` is high.
- R3: The slot after the last address bit carries the even parity of the address: 1 when the address has an odd number of ones.
- R4: Each field ends with an acknowledge slot. In that slot `tx_bit_o` is 1 and `ack_slot_o` is 1; in every other slot `ack_slot_o` is 0. `ack_in_i` is sampled on the strobe that ends the slot, and 0 means acknowledged.
- R5: An acknowledged address slot is followed by the 4 control bits, most significant bit first.
- R6: The slot after the last control bit carries the even parity of the control code.
- R7: A non-broadcast transfer with `ack_in_i` = 1 in the address acknowledge slot raises `abort_o` for one cycle and returns to idle. No control bits are sent.
- R8: A non-broadcast transfer with `ack_in_i` = 1 in the control acknowledge slot raises `abort_o` for one cycle and returns to idle.
- R9: With the broadcast flag captured at start, both acknowledge slots are passed whatever `ack_in_i` holds, and the transfer ends with `done_o`.
- R10: `done_o` is high for exactly one cycle, on the cycle after the strobe that ends an accepted control acknowledge slot. The block is idle on that same cycle.
- R11: A start pulse during a transfer has no effect: the address, control code and broadcast flag captured at the first start keep being used.
- R12: Between strobes, `tx_bit_o` and `ack_slot_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; accepted only while idle |
| tgt_addr_i | input | 12 | Target slave address |
| bcast_i | input | 1 | Broadcast transfer flag |
| ctrl_code_i | input | 4 | Control code |
| slot_stb_i | input | 1 | End-of-slot strobe |
| ack_in_i | input | 1 | Sampled line level in acknowledge slots (0 = acknowledge) |
| tx_bit_o | output | 1 | Bit driven for the current slot (1 = released) |
| ack_slot_o | output | 1 | High during an acknowledge slot |
| done_o | output | 1 | One-cycle success pulse |
| abort_o | output | 1 | One-cycle abort-to-monitor pulse |

## Verification
Addresses and control codes with odd and even numbers of ones show whether each parity bit follows its own field. Asymmetric values such as 0xA5C show whether the bit order is reversed. Four acknowledge patterns separate the outcomes: both acknowledged, address refused, control refused, and broadcast with the line held high. A refused address must end with no control bits, and a broadcast must finish although no slave answered. A second start with a different address in mid-transfer shows whether the captured values are protected. Every slot is sampled twice before its strobe, which shows whether the outputs move between strobes.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int FSEQ_ADDR_W = 12;
    localparam int FSEQ_CTRL_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_APAR,
        PH_AACK,
        PH_CTRL,
        PH_CPAR,
        PH_CACK
    } phase_e;

    typedef enum logic [2:0] {
        SRC_IDLE,
        SRC_ABIT,
        SRC_APAR,
        SRC_CBIT,
        SRC_CPAR,
        SRC_ACK
    } txsrc_e;

    typedef struct packed {
        logic done;
        logic abort;
    } outcome_t;

    // An acknowledge slot passes on a sampled low, or always in broadcast mode
    function automatic logic ack_accepted(input logic bcast, input logic line);
        return bcast | ~line;
    endfunction

endpackage

// File: rtl/fseq_field_ser.sv
module fseq_field_ser #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         shift_i,
    output logic         bit_o,
    output logic         par_o,
    output logic         last_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;
    logic          par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
            par_q <= 1'b0;
        end else if (load_i) begin
            sh_q  <= data_i;
            cnt_q <= '0;
            par_q <= ^data_i;
        end else if (shift_i) begin
            sh_q  <= {sh_q[W-2:0], 1'b0};
            cnt_q <= (cnt_q == LAST_IDX) ? cnt_q : cnt_q + 1'b1;
        end
    end

    assign bit_o  = sh_q[W-1];
    assign par_o  = par_q;
    assign last_o = (cnt_q == LAST_IDX);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_IDX); // R2

    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/fseq_seq_ctrl.sv
module fseq_seq_ctrl
    import fseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  logic   bcast_i,
    input  logic   stb_i,
    input  logic   ack_in_i,
    input  logic   a_last_i,
    input  logic   c_last_i,
    output logic   load_o,
    output logic   a_shift_o,
    output logic   c_shift_o,
    output txsrc_e src_o,
    output logic   ack_slot_o,
    output logic   busy_o,
    output logic   done_o,
    output logic   abort_o
);
    phase_e   phase_q;
    logic     bcast_q;
    outcome_t res_q;

    assign load_o    = start_i && (phase_q == PH_IDLE);
    assign a_shift_o = stb_i && (phase_q == PH_ADDR);
    assign c_shift_o = stb_i && (phase_q == PH_CTRL);
    assign busy_o    = (phase_q != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            bcast_q <= 1'b0;
            res_q   <= '0;
        end else begin
            res_q <= '0;
            if (load_o) begin
                phase_q <= PH_ADDR;
                bcast_q <= bcast_i;
            end else if (stb_i) begin
                unique case (phase_q)
                    PH_ADDR: if (a_last_i) phase_q <= PH_APAR;
                    PH_APAR: phase_q <= PH_AACK;
                    PH_AACK: begin
                        if (ack_accepted(bcast_q, ack_in_i)) begin
                            phase_q <= PH_CTRL;
                        end else begin
                            phase_q     <= PH_IDLE;
                            res_q.abort <= 1'b1;
                        end
                    end
                    PH_CTRL: if (c_last_i) phase_q <= PH_CPAR;
                    PH_CPAR: phase_q <= PH_CACK;
                    PH_CACK: begin
                        phase_q <= PH_IDLE;
                        if (ack_accepted(bcast_q, ack_in_i)) res_q.done  <= 1'b1;
                        else                                 res_q.abort <= 1'b1;
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        unique case (phase_q)
            PH_ADDR:          src_o = SRC_ABIT;
            PH_APAR:          src_o = SRC_APAR;
            PH_CTRL:          src_o = SRC_CBIT;
            PH_CPAR:          src_o = SRC_CPAR;
            PH_AACK, PH_CACK: src_o = SRC_ACK;
            default:          src_o = SRC_IDLE;
        endcase
    end

    assign ack_slot_o = (src_o == SRC_ACK);
    assign done_o     = res_q.done;
    assign abort_o    = res_q.abort;

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !stb_i) |=> $stable(phase_q)); // R11

    AST_NACK_ABORTS: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_AACK && stb_i && !bcast_q && ack_in_i) |=> (abort_o && !busy_o)); // R7

    AST_BCAST_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
        ((phase_q == PH_AACK || phase_q == PH_CACK) && stb_i && bcast_q) |=> !abort_o); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10

    AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_o && abort_o)); // R8

endmodule

// File: rtl/fseq_master.sv
module fseq_master
    import fseq_pkg::*;
#(
    parameter int ADDR_W = FSEQ_ADDR_W,
    parameter int CTRL_W = FSEQ_CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] tgt_addr_i,
    input  logic              bcast_i,
    input  logic [CTRL_W-1:0] ctrl_code_i,
    input  logic              slot_stb_i,
    input  logic              ack_in_i,
    output logic              tx_bit_o,
    output logic              ack_slot_o,
    output logic              done_o,
    output logic              abort_o
);
    logic   load, a_shift, c_shift, busy;
    logic   a_bit, a_par, a_last;
    logic   c_bit, c_par, c_last;
    txsrc_e src;

    fseq_field_ser #(.W(ADDR_W)) addr_ser_i (
        .clk(clk), .rst(rst), .load_i(load), .data_i(tgt_addr_i),
        .shift_i(a_shift), .bit_o(a_bit), .par_o(a_par), .last_o(a_last)
    );

    fseq_field_ser #(.W(CTRL_W)) ctrl_ser_i (
        .clk(clk), .rst(rst), .load_i(load), .data_i(ctrl_code_i),
        .shift_i(c_shift), .bit_o(c_bit), .par_o(c_par), .last_o(c_last)
    );

    fseq_seq_ctrl ctrl_i (
        .clk(clk), .rst(rst), .start_i(start_i), .bcast_i(bcast_i),
        .stb_i(slot_stb_i), .ack_in_i(ack_in_i),
        .a_last_i(a_last), .c_last_i(c_last),
        .load_o(load), .a_shift_o(a_shift), .c_shift_o(c_shift),
        .src_o(src), .ack_slot_o(ack_slot_o), .busy_o(busy),
        .done_o(done_o), .abort_o(abort_o)
    );

    always_comb begin
        unique case (src)
            SRC_ABIT: tx_bit_o = a_bit;
            SRC_APAR: tx_bit_o = a_par;
            SRC_CBIT: tx_bit_o = c_bit;
            SRC_CPAR: tx_bit_o = c_par;
            default:  tx_bit_o = 1'b1;
        endcase
    end

    AST_ACK_RECESSIVE: assert property (@(posedge clk) disable iff (rst)
        ack_slot_o |-> tx_bit_o); // R4

    AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (rst)
        (busy && !slot_stb_i) |=> ($stable(tx_bit_o) && $stable(ack_slot_o))); // R12

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (!busy) |-> (tx_bit_o && !ack_slot_o)); // R1

endmodule

// File: tb/fseq_master_tb_top.sv
module fseq_master_tb_top;

    typedef struct {
        logic  txb;
        logic  ackf;
        string tag;
    } slot_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [11:0] tgt_addr_i = '0;
    logic        bcast_i = 1'b0;
    logic [3:0]  ctrl_code_i = '0;
    logic        slot_stb_i = 1'b0;
    logic        ack_in_i = 1'b1;
    logic        tx_bit_o, ack_slot_o, done_o, abort_o;

    int n_checks = 0;
    int n_fail   = 0;
    slot_t exp_q[$];

    always #10 clk = ~clk;

    fseq_master dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .tgt_addr_i(tgt_addr_i),
        .bcast_i(bcast_i), .ctrl_code_i(ctrl_code_i), .slot_stb_i(slot_stb_i),
        .ack_in_i(ack_in_i), .tx_bit_o(tx_bit_o), .ack_slot_o(ack_slot_o),
        .done_o(done_o), .abort_o(abort_o)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Driver side: push the expected slot sequence
    task automatic push_slots(input logic [11:0] a, input logic [3:0] c,
                              input logic bc, input logic a_ok);
        for (int i = 11; i >= 0; i--) exp_q.push_back('{a[i], 1'b0, "R2"});
        exp_q.push_back('{^a, 1'b0, "R3"});
        exp_q.push_back('{1'b1, 1'b1, "R4"});
        if (bc || a_ok) begin
            for (int i = 3; i >= 0; i--) exp_q.push_back('{c[i], 1'b0, "R5"});
            exp_q.push_back('{^c, 1'b0, "R6"});
            exp_q.push_back('{1'b1, 1'b1, "R4"});
        end
    endtask

    // Monitor side: pop one expected slot and compare the outputs
    task automatic mon_slot(input slot_t e, input logic second);
        chk(second ? "R12" : e.tag, {2'b00, tx_bit_o, ack_slot_o}, {2'b00, e.txb, e.ackf});
    endtask

    task automatic run_seq(input logic [11:0] a, input logic [3:0] c, input logic bc,
                           input logic a_ok, input logic c_ok, input logic inject);
        int    k;
        slot_t e;
        logic  exp_done;
        exp_done = bc || (a_ok && c_ok);
        push_slots(a, c, bc, a_ok);
        tgt_addr_i = a; ctrl_code_i = c; bcast_i = bc;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 0;
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            mon_slot(e, 1'b0);
            if (inject && k == 3) begin
                // R11: second start with other values mid-transfer
                tgt_addr_i = ~a; ctrl_code_i = ~c; bcast_i = ~bc; start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            mon_slot(e, 1'b1);
            if (e.ackf) ack_in_i = (k < 14) ? ~a_ok : ~c_ok;
            else        ack_in_i = 1'b0;
            slot_stb_i = 1'b1;
            @(negedge clk);
            slot_stb_i = 1'b0;
            ack_in_i = 1'b1;
            k++;
        end
        chk(exp_done ? "R10" : (a_ok ? "R8" : "R7"), {2'b00, done_o, abort_o},
            {2'b00, exp_done, ~exp_done});
        if (bc) chk("R9", {3'b000, done_o}, 4'b0001);
        @(negedge clk);
        chk("R10", {2'b00, done_o, abort_o}, 4'b0000);
        chk("R1", {2'b00, tx_bit_o, ack_slot_o}, 4'b0010);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst = 1'b0;
                chk("R1", {tx_bit_o, ack_slot_o, done_o, abort_o}, 4'b1000);
                run_seq(12'hA5C, 4'h6, 1'b0, 1'b1, 1'b1, 1'b0);
                run_seq(12'h123, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0); // R7
                run_seq(12'h801, 4'h7, 1'b0, 1'b1, 1'b0, 1'b0); // R8
                run_seq(12'hFFF, 4'h3, 1'b1, 1'b0, 1'b0, 1'b0); // R9
                run_seq(12'h3C1, 4'h1, 1'b0, 1'b1, 1'b1, 1'b1); // R11
                run_seq(12'h700, 4'h8, 1'b1, 1'b0, 1'b0, 1'b1); // R11 with broadcast
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule